// File: doc/BRIEF.md
# Serial Control Register With Latch Decode

This block is the write-only configuration port of a clock-synthesis controller. An external host drives three wires: a serial clock, a serial data line and a load strobe. Each rising serial-clock edge pushes one data bit into a 24-bit shift register, most significant bit first. A rising edge on the load strobe copies the word into one of four configuration latches. The two least significant bits of the word select the latch. The latch fields drive the configuration outputs of the reference divider, the feedback divider and the function controls.

The fourth latch is a combined initialization and function latch. Writing it loads the same fields as a function write. It also sends a one-cycle reset pulse to the dividers and the timeout counter, and it arms a second pulse. That second pulse fires on the next feedback-divider load only. The counter-reset field drives a hold signal for the dividers and forces the charge pump off. A hardware request can clear the stored feedback gain bit. All three serial pins are sampled in the faster system clock domain through synchronizers.

Top module: `ctl_word_port`

## Requirements
- R1: Data is shifted in MSB first on rising serial-clock edges. When the load strobe rises, only the last 24 bits shifted in are used, and earlier bits are dropped.
- R2: On a load-strobe rising edge, word bits [1:0] pick the target latch: 00 reference, 01 feedback, 10 function, 11 initialization. No other latch changes.
- R3: A reference write takes the divide value from [15:2], the antibacklash width from [17:16], the test bits from [19:18] and the lock-precision bit from [20]. Bits [23:21] are ignored.
- R4: A feedback write takes the divide value from [20:8] and the gain bit from [21]. Bits [7:2] and [23:22] are ignored.
- R5: A function write sets these fields: counter reset [2], power-down-1 [3], output select [6:4], detector polarity [7], charge-pump off [8], fastlock enable [9], fastlock mode [10], timeout code [14:11], current 1 [17:15], current 2 [20:18] and power-down-2 [21].
- R6: An initialization write loads the same function fields as R5 and emits the divider reset pulse.
- R7: The first feedback write after an initialization write emits the reset pulse. Later feedback writes do not, until the next initialization write. Reference and function writes neither arm nor disarm this pulse.
- R8: The reset pulse is high for exactly one system-clock cycle. It appears in the same cycle as the latch update, on the third system-clock edge after the load strobe goes high.
- R9: The divider hold output equals the stored counter-reset bit. The charge-pump-off output is high when the counter-reset bit or the charge-pump off bit is set.
- R10: Setting either power-down bit does not stop later words from being latched.
- R11: A gain-clear request clears the stored gain bit at the next clock edge. It wins over a feedback write in the same cycle and leaves the divide value unchanged.
- R12: After reset every configuration output is zero and no reset pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, sampled |
| ser_data | input | 1 | Serial data, sampled |
| ser_load | input | 1 | Load strobe, latched on rising edge |
| gain_clr_req | input | 1 | Hardware request to clear the gain bit |
| ref_div_o | output | 14 | Reference divide value |
| ref_abw_o | output | 2 | Antibacklash width code |
| ref_test_o | output | 2 | Test bits |
| ref_lock_prec_o | output | 1 | Lock-detect precision |
| fb_div_o | output | 13 | Feedback divide value |
| fb_gain_o | output | 1 | Gain bit |
| fn_cnt_rst_o | output | 1 | Counter reset field |
| fn_pd1_o | output | 1 | Power-down bit 1 |
| fn_out_sel_o | output | 3 | Output select code |
| fn_det_pol_o | output | 1 | Detector polarity |
| fn_cp_hiz_o | output | 1 | Charge-pump off field |
| fn_fl_en_o | output | 1 | Fastlock enable |
| fn_fl_mode_o | output | 1 | Fastlock mode |
| fn_tmo_o | output | 4 | Timeout code |
| fn_cur1_o | output | 3 | Current setting 1 |
| fn_cur2_o | output | 3 | Current setting 2 |
| fn_pd2_o | output | 1 | Power-down bit 2 |
| div_hold_o | output | 1 | Hold both dividers at load point |
| cp_off_o | output | 1 | Effective charge-pump three-state |
| div_reset_pulse_o | output | 1 | One-cycle divider/timeout reset |

## Verification
The load strobe passes two synchronizer flops and an edge-detect flop. The latch outputs and the reset pulse therefore change on the third system-clock edge after the strobe rises. The pulse falls again on the fourth edge. The bench drives every input just after a falling clock edge and samples the outputs at falling edges. The timed test checks the strobe at the first through fourth falling edges: the pulse is low, low, high, then low. The gain-clear request needs one edge. The bench holds it for exactly the third-edge cycle to test the collision with a feedback write. Table entries are checked only after the strobe window has closed, and pulses are counted over that whole window.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int WORD_W   = 24;
  localparam int TGT_W    = 2;
  localparam int RDIV_W   = 14;
  localparam int FDIV_W   = 13;
  localparam int ABW_W    = 2;
  localparam int TST_W    = 2;
  localparam int OSEL_W   = 3;
  localparam int TMO_W    = 4;
  localparam int CUR_W    = 3;

  // field positions that the neighbouring decode depends on
  localparam int RDIV_LSB = 2;
  localparam int ABW_LSB  = RDIV_LSB + RDIV_W;
  localparam int TST_LSB  = ABW_LSB + ABW_W;
  localparam int LPR_BIT  = TST_LSB + TST_W;
  localparam int FDIV_LSB = 8;
  localparam int GAIN_BIT = FDIV_LSB + FDIV_W;
  localparam int CRST_BIT = 2;
  localparam int PD1_BIT  = 3;
  localparam int OSEL_LSB = 4;
  localparam int POL_BIT  = OSEL_LSB + OSEL_W;
  localparam int HIZ_BIT  = POL_BIT + 1;
  localparam int FLE_BIT  = HIZ_BIT + 1;
  localparam int FLM_BIT  = FLE_BIT + 1;
  localparam int TMO_LSB  = FLM_BIT + 1;
  localparam int CUR1_LSB = TMO_LSB + TMO_W;
  localparam int CUR2_LSB = CUR1_LSB + CUR_W;
  localparam int PD2_BIT  = CUR2_LSB + CUR_W;

  typedef enum logic [TGT_W-1:0] {
    TGT_REF  = 2'b00,
    TGT_FB   = 2'b01,
    TGT_FUNC = 2'b10,
    TGT_INIT = 2'b11
  } tgt_e;

  typedef struct packed {
    logic [RDIV_W-1:0] div;
    logic [ABW_W-1:0]  abw;
    logic [TST_W-1:0]  tst;
    logic              lock_prec;
  } ref_cfg_t;

  typedef struct packed {
    logic [FDIV_W-1:0] div;
    logic              gain;
  } fb_cfg_t;

  typedef struct packed {
    logic              cnt_rst;
    logic              pd1;
    logic [OSEL_W-1:0] out_sel;
    logic              det_pol;
    logic              cp_hiz;
    logic              fl_en;
    logic              fl_mode;
    logic [TMO_W-1:0]  tmo;
    logic [CUR_W-1:0]  cur1;
    logic [CUR_W-1:0]  cur2;
    logic              pd2;
  } func_cfg_t;

  function automatic tgt_e word_target(input logic [WORD_W-1:0] w);
    return tgt_e'(w[TGT_W-1:0]);
  endfunction

  function automatic ref_cfg_t unpack_ref(input logic [WORD_W-1:0] w);
    ref_cfg_t c;
    c.div       = w[RDIV_LSB +: RDIV_W];
    c.abw       = w[ABW_LSB +: ABW_W];
    c.tst       = w[TST_LSB +: TST_W];
    c.lock_prec = w[LPR_BIT];
    return c;
  endfunction

  function automatic fb_cfg_t unpack_fb(input logic [WORD_W-1:0] w);
    fb_cfg_t c;
    c.div  = w[FDIV_LSB +: FDIV_W];
    c.gain = w[GAIN_BIT];
    return c;
  endfunction

  function automatic func_cfg_t unpack_func(input logic [WORD_W-1:0] w);
    func_cfg_t c;
    c.cnt_rst = w[CRST_BIT];
    c.pd1     = w[PD1_BIT];
    c.out_sel = w[OSEL_LSB +: OSEL_W];
    c.det_pol = w[POL_BIT];
    c.cp_hiz  = w[HIZ_BIT];
    c.fl_en   = w[FLE_BIT];
    c.fl_mode = w[FLM_BIT];
    c.tmo     = w[TMO_LSB +: TMO_W];
    c.cur1    = w[CUR1_LSB +: CUR_W];
    c.cur2    = w[CUR2_LSB +: CUR_W];
    c.pd2     = w[PD2_BIT];
    return c;
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/cfg_latches.sv
module cfg_latches
  import ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] word,
  input  logic              gain_clr,
  output ref_cfg_t          ref_q,
  output fb_cfg_t           fb_q,
  output func_cfg_t         func_q,
  output logic              init_wr,
  output logic              fb_wr
);
  tgt_e tgt;
  assign tgt     = word_target(word);
  assign init_wr = load_stb && (tgt == TGT_INIT);
  assign fb_wr   = load_stb && (tgt == TGT_FB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      fb_q   <= '0;
      func_q <= '0;
    end else begin
      if (load_stb) begin
        unique case (tgt)
          TGT_REF:            ref_q  <= unpack_ref(word);
          TGT_FB:             fb_q   <= unpack_fb(word);
          TGT_FUNC, TGT_INIT: func_q <= unpack_func(word);
          default:            ;
        endcase
      end
      // hardware clear wins over a software write in the same cycle
      if (gain_clr) fb_q.gain <= 1'b0;
    end
  end
endmodule

// File: rtl/init_pulse_gen.sv
module init_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic init_wr,
  input  logic fb_wr,
  output logic pulse,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      armed <= 1'b0;
    end else if (init_wr) begin
      pulse <= 1'b1;
      armed <= 1'b1;
    end else if (fb_wr && armed) begin
      pulse <= 1'b1;
      armed <= 1'b0;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_word_port.sv
module ctl_word_port
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  input  logic              gain_clr_req,
  output logic [RDIV_W-1:0] ref_div_o,
  output logic [ABW_W-1:0]  ref_abw_o,
  output logic [TST_W-1:0]  ref_test_o,
  output logic              ref_lock_prec_o,
  output logic [FDIV_W-1:0] fb_div_o,
  output logic              fb_gain_o,
  output logic              fn_cnt_rst_o,
  output logic              fn_pd1_o,
  output logic [OSEL_W-1:0] fn_out_sel_o,
  output logic              fn_det_pol_o,
  output logic              fn_cp_hiz_o,
  output logic              fn_fl_en_o,
  output logic              fn_fl_mode_o,
  output logic [TMO_W-1:0]  fn_tmo_o,
  output logic [CUR_W-1:0]  fn_cur1_o,
  output logic [CUR_W-1:0]  fn_cur2_o,
  output logic              fn_pd2_o,
  output logic              div_hold_o,
  output logic              cp_off_o,
  output logic              div_reset_pulse_o
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_q;
  logic sck_q, sdi_q, sle_q;
  logic sck_d, sle_d;
  logic sck_rise, load_stb;
  logic [WORD_W-1:0] shift_word;
  ref_cfg_t  ref_q;
  fb_cfg_t   fb_q;
  func_cfg_t func_q;
  logic init_wr, fb_wr, arm_q;

  bit_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_clk, ser_data, ser_load}),
    .q    (pins_q)
  );
  assign {sck_q, sdi_q, sle_q} = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sle_d <= 1'b0;
    end else begin
      sck_d <= sck_q;
      sle_d <= sle_q;
    end
  end

  assign sck_rise = sck_q && !sck_d;
  assign load_stb = sle_q && !sle_d;

  word_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sck_rise),
    .din     (sdi_q),
    .word    (shift_word)
  );

  cfg_latches u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_stb(load_stb),
    .word    (shift_word),
    .gain_clr(gain_clr_req),
    .ref_q   (ref_q),
    .fb_q    (fb_q),
    .func_q  (func_q),
    .init_wr (init_wr),
    .fb_wr   (fb_wr)
  );

  init_pulse_gen u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_wr(init_wr),
    .fb_wr  (fb_wr),
    .pulse  (div_reset_pulse_o),
    .armed  (arm_q)
  );

  assign ref_div_o       = ref_q.div;
  assign ref_abw_o       = ref_q.abw;
  assign ref_test_o      = ref_q.tst;
  assign ref_lock_prec_o = ref_q.lock_prec;
  assign fb_div_o        = fb_q.div;
  assign fb_gain_o       = fb_q.gain;
  assign fn_cnt_rst_o    = func_q.cnt_rst;
  assign fn_pd1_o        = func_q.pd1;
  assign fn_out_sel_o    = func_q.out_sel;
  assign fn_det_pol_o    = func_q.det_pol;
  assign fn_cp_hiz_o     = func_q.cp_hiz;
  assign fn_fl_en_o      = func_q.fl_en;
  assign fn_fl_mode_o    = func_q.fl_mode;
  assign fn_tmo_o        = func_q.tmo;
  assign fn_cur1_o       = func_q.cur1;
  assign fn_cur2_o       = func_q.cur2;
  assign fn_pd2_o        = func_q.pd2;
  assign div_hold_o      = func_q.cnt_rst;
  assign cp_off_o        = func_q.cnt_rst | func_q.cp_hiz;
endmodule

// File: rtl/ctl_word_port_chk.sv
module ctl_word_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_stb,
  input logic        init_wr,
  input logic        fb_wr,
  input logic        armed,
  input logic        gain_clr_req,
  input logic        div_reset_pulse,
  input logic        fb_gain,
  input logic [13:0] ref_div,
  input logic [12:0] fb_div
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset_pulse |=> !div_reset_pulse); // R8

  AST_PULSE_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset_pulse |-> $past(load_stb)); // R8

  AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> div_reset_pulse); // R6

  AST_FB_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_wr && !armed) |=> !div_reset_pulse); // R7

  AST_FB_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_wr && armed) |=> !armed); // R7

  AST_GAIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr_req |=> !fb_gain); // R11

  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_stb) |-> $stable(ref_div)); // R2

  AST_FB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_stb) |-> $stable(fb_div)); // R2
endmodule

bind ctl_word_port ctl_word_port_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .load_stb       (load_stb),
  .init_wr        (init_wr),
  .fb_wr          (fb_wr),
  .armed          (arm_q),
  .gain_clr_req   (gain_clr_req),
  .div_reset_pulse(div_reset_pulse_o),
  .fb_gain        (fb_gain_o),
  .ref_div        (ref_div_o),
  .fb_div         (fb_div_o)
);

// File: tb/sim_ctl_word_port.sv
`timescale 1ns/1ps
module sim_ctl_word_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, gain_clr_req = 1'b0;
  logic [13:0] ref_div_o;
  logic [1:0]  ref_abw_o, ref_test_o;
  logic        ref_lock_prec_o;
  logic [12:0] fb_div_o;
  logic        fb_gain_o;
  logic        fn_cnt_rst_o, fn_pd1_o, fn_det_pol_o, fn_cp_hiz_o, fn_fl_en_o, fn_fl_mode_o, fn_pd2_o;
  logic [2:0]  fn_out_sel_o, fn_cur1_o, fn_cur2_o;
  logic [3:0]  fn_tmo_o;
  logic        div_hold_o, cp_off_o, div_reset_pulse_o;

  always #4 clk = ~clk;

  ctl_word_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .gain_clr_req(gain_clr_req),
    .ref_div_o(ref_div_o), .ref_abw_o(ref_abw_o), .ref_test_o(ref_test_o),
    .ref_lock_prec_o(ref_lock_prec_o), .fb_div_o(fb_div_o), .fb_gain_o(fb_gain_o),
    .fn_cnt_rst_o(fn_cnt_rst_o), .fn_pd1_o(fn_pd1_o), .fn_out_sel_o(fn_out_sel_o),
    .fn_det_pol_o(fn_det_pol_o), .fn_cp_hiz_o(fn_cp_hiz_o), .fn_fl_en_o(fn_fl_en_o),
    .fn_fl_mode_o(fn_fl_mode_o), .fn_tmo_o(fn_tmo_o), .fn_cur1_o(fn_cur1_o),
    .fn_cur2_o(fn_cur2_o), .fn_pd2_o(fn_pd2_o), .div_hold_o(div_hold_o),
    .cp_off_o(cp_off_o), .div_reset_pulse_o(div_reset_pulse_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int pulse_seen = 0;

  // bench model of the stored configuration
  logic [13:0] e_rdiv = '0;
  logic [4:0]  e_rmisc = '0;   // {lock_prec, test, abw}
  logic [12:0] e_fdiv = '0;
  logic        e_gain = 1'b0;
  logic [19:0] e_fn = '0;      // word bits 21..2 of the last function-type write

  // bit 24: pulse expected for this load
  localparam logic [24:0] VEC [13] = '{
    {1'b0, 24'hFFFFFC},  // ref, all fields ones, reserved ignored
    {1'b0, 24'h2AAB55},  // fb, not armed
    {1'b0, 24'h15A5A6},  // function
    {1'b1, 24'h2B3C73},  // init: pulse, arm
    {1'b0, 24'h123450},  // ref keeps arm
    {1'b0, 24'h0ABCDA},  // function keeps arm
    {1'b1, 24'h1FFF01},  // first fb after init
    {1'b0, 24'hE00FFD},  // later fb: quiet
    {1'b1, 24'h000007},  // init with counter reset set
    {1'b1, 24'h200001},  // fb after init
    {1'b0, 24'h20000A},  // function, both power-down bits
    {1'b0, 24'h00ABCC},  // ref while powered down
    {1'b0, 24'h000101}   // fb, no pulse
  };

  always @(negedge clk) if (div_reset_pulse_o === 1'b1) pulse_seen++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] act_fn();
    return {fn_pd2_o, fn_cur2_o, fn_cur1_o, fn_tmo_o, fn_fl_mode_o, fn_fl_en_o,
            fn_cp_hiz_o, fn_det_pol_o, fn_out_sel_o, fn_pd1_o, fn_cnt_rst_o};
  endfunction

  task automatic model_load(input logic [23:0] w);
    case (w[1:0])
      2'b00: begin e_rdiv = w[15:2]; e_rmisc = {w[20], w[19:18], w[17:16]}; end
      2'b01: begin e_fdiv = w[20:8]; e_gain = w[21]; end
      default: e_fn = w[21:2];
    endcase
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) ser_data = bits[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    pulse_seen = 0;
    ser_load = 1'b1;
    repeat (5) @(negedge clk);
    ser_load = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 ref"}, 64'({ref_div_o, ref_lock_prec_o, ref_test_o, ref_abw_o}),
        64'({e_rdiv, e_rmisc}));
    chk({tag, " R4 fb"}, 64'({fb_div_o, fb_gain_o}), 64'({e_fdiv, e_gain}));
    chk({tag, " R5 func"}, 64'(act_fn()), 64'(e_fn));
    chk({tag, " R9 hold/cp"}, 64'({div_hold_o, cp_off_o}),
        64'({e_fn[0], e_fn[0] | e_fn[6]}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state
    check_all("R12 reset");
    chk("R12 no pulse", 64'(div_reset_pulse_o), 64'd0);

    // table walk: R2 routing, R6 init, R7 arm rules, R10 power-down
    for (int i = 0; i < 13; i++) begin
      shift_bits(32'(VEC[i][23:0]), 24);
      strobe();
      model_load(VEC[i][23:0]);
      check_all((i >= 10) ? "R10 R2 table" : "R2 table");
      chk("R7 R6 pulse count", 64'(pulse_seen), 64'(VEC[i][24]));
    end

    // R1: 28 bits shifted, only the last 24 count
    shift_bits({4'hF, 4'h0, 24'h000501}, 28);
    strobe();
    model_load(24'h000501);
    chk("R1 last 24 bits", 64'({fb_div_o, fb_gain_o}), 64'({13'd5, 1'b0}));
    chk("R1 no pulse", 64'(pulse_seen), 64'd0);

    // R8 exact timing of an init write
    shift_bits(32'(24'h000013), 24);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk) chk("R8 edge1 pulse", 64'(div_reset_pulse_o), 64'd0);
    @(negedge clk) chk("R8 edge2 pulse", 64'(div_reset_pulse_o), 64'd0);
    chk("R8 edge2 old func", 64'(act_fn()), 64'(e_fn));
    @(negedge clk) chk("R8 edge3 pulse", 64'(div_reset_pulse_o), 64'd1);
    chk("R8 edge3 out_sel", 64'(fn_out_sel_o), 64'd1);
    @(negedge clk) chk("R8 edge4 pulse", 64'(div_reset_pulse_o), 64'd0);
    ser_load = 1'b0;
    repeat (3) @(negedge clk);
    model_load(24'h000013);
    check_all("R6 init");

    // arm consumed by a gain=1 write
    shift_bits(32'(24'h200901), 24);
    strobe();
    model_load(24'h200901);
    chk("R7 first fb pulse", 64'(pulse_seen), 64'd1);
    chk("R4 gain set", 64'(fb_gain_o), 64'd1);

    // R11 collision: clear in the same cycle as the write
    shift_bits(32'(24'h200A01), 24);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    @(negedge clk) gain_clr_req = 1'b1;
    @(negedge clk) gain_clr_req = 1'b0;
    chk("R11 clear wins", 64'(fb_gain_o), 64'd0);
    chk("R11 div written", 64'(fb_div_o), 64'h00A);
    ser_load = 1'b0;
    repeat (3) @(negedge clk);

    // R11 clear alone
    shift_bits(32'(24'h200B01), 24);
    strobe();
    chk("R11 gain before", 64'(fb_gain_o), 64'd1);
    @(negedge clk) gain_clr_req = 1'b1;
    @(negedge clk) gain_clr_req = 1'b0;
    chk("R11 gain cleared", 64'(fb_gain_o), 64'd0);
    chk("R11 div kept", 64'(fb_div_o), 64'h00B);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule